// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This block is one down-counting timer that a processor reaches through a small synchronous register bus: a word address, a write strobe, write data and combinational read data. A tick-enable input stands for the timer clock. Each tick passes through a selectable prescaler, and the counter steps down once per prescaled tick. When the count expires, a sticky raw flag is set. That flag, gated by an enable bit, drives a level interrupt.

Software picks the counter width (16 or 32 bits), the prescale ratio, and one of three ways to behave at expiry. In free-running mode the counter wraps to the all-ones value of its width. In periodic mode it reloads from the stored limit. In one-shot mode it halts at zero. The limit can be written in two ways. The immediate form also reloads the counter. The background form changes only the value used at the next periodic reload.

Top module: `tmr_down_timer`

## Requirements
- R1: After reset, the control register reads 0x20 (interrupt enable only). The limit, the count and the raw flag read 0, and `irq` is low.
- R2: Word addresses: 0 immediate limit, 1 count, 2 control, 3 flag clear (write only), 4 raw flag, 5 masked flag, 6 background limit. Addresses 0 and 6 both read the stored limit. Addresses 3 and 7 read 0. Flag reads return the flag in bit 0.
- R3: Control bits: 0 one-shot, 1 32-bit width, 3:2 prescale select, 5 interrupt enable, 6 periodic, 7 run. Write data bits 31:8 are dropped, and control reads back as its 8 stored bits.
- R4: The counter steps only on a tick while run is set. Select 00 and 11 step on every tick, 01 on every 16th tick, and 10 on every 256th tick. A control write that changes the select restarts the prescaler.
- R5: Each prescaled tick on a non-zero count subtracts one. In 16-bit mode only bits 15:0 count, and the count reads with bits 31:16 zero.
- R6: With periodic clear and one-shot clear, a tick on a zero count wraps the counter to 0xFFFF (16-bit) or 0xFFFFFFFF (32-bit).
- R7: With periodic set, a tick on a zero count reloads the stored limit.
- R8: With one-shot set, a tick on a zero count raises the flag and halts the counter at zero. A later write to address 0 or 2 lets it run again.
- R9: A write to address 0 stores the limit and loads the counter with it. A write to address 6 stores the limit and leaves the count unchanged.
- R10: Writes to address 1 change nothing.
- R11: A tick on a zero count sets the raw flag. The flag stays set until any write to address 3. When both happen in the same cycle, the set wins.
- R12: `irq` and the masked status both equal the raw flag ANDed with control bit 5.
- R13: A write to address 0 in the same cycle as a prescaled tick loads the written value, and the tick is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Timer clock enable, one tick per cycle high |
| bus_addr | input | 3 | Word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the bus carries at most one access per cycle. They also assume that a change of the prescale select happens only through a control write, and that no write lands while the internal reset is still held after `rst_n` rises. The stimulus holds the bus idle for several cycles after reset. It then issues single-cycle writes only, one address at a time, so the value-write, prescale and halt properties see exactly the inputs they assume. A random phase lets writes to any address fall next to ticks and expiries, which covers the cases where set and clear collide.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       ie;
    logic       spare;
    logic [1:0] div_sel;
    logic       wide;
    logic       oneshot;
  } tmr_ctrl_t;

  localparam logic [7:0] CTRL_RST = 8'h20;

  localparam logic [ADDR_W-1:0] RA_LOAD   = 3'd0;
  localparam logic [ADDR_W-1:0] RA_VALUE  = 3'd1;
  localparam logic [ADDR_W-1:0] RA_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] RA_ICLR   = 3'd3;
  localparam logic [ADDR_W-1:0] RA_RAW    = 3'd4;
  localparam logic [ADDR_W-1:0] RA_MASKED = 3'd5;
  localparam logic [ADDR_W-1:0] RA_BGLOAD = 3'd6;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  input  logic       clr_i,
  output logic       ptick_o
);
  localparam logic [PRE_W-1:0] MASK_16  = PRE_W'(15);
  localparam logic [PRE_W-1:0] MASK_256 = '1;

  logic [PRE_W-1:0] pre_q, pre_d, mask;

  always_comb begin
    case (sel_i)
      2'b01:   mask = MASK_16;
      2'b10:   mask = MASK_256;
      default: mask = '0;
    endcase
  end

  assign ptick_o = run_i & tick_i & ((pre_q & mask) == mask);

  always_comb begin
    pre_d = pre_q;
    if (clr_i)               pre_d = '0;
    else if (run_i & tick_i) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R4
  div16_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptick_o && sel_i == 2'b01 && !clr_i) |=> !ptick_o);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptick_i,
  input  logic              wide_i,
  input  logic              periodic_i,
  input  logic              oneshot_i,
  input  logic [DATA_W-1:0] limit_i,
  input  logic              load_wr_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              ctrl_wr_i,
  input  logic              iclr_wr_i,
  output logic [DATA_W-1:0] value_o,
  output logic              raw_o,
  output logic              halted_o
);
  localparam logic [DATA_W-1:0] NARROW_MAX = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [DATA_W-1:0] FULL_MAX   = '1;

  logic [DATA_W-1:0] cnt_q, cnt_d, top;
  logic              raw_q, raw_d, halt_q, halt_d, at_zero, expire;

  assign top     = wide_i ? FULL_MAX : NARROW_MAX;
  assign value_o = cnt_q & top;
  assign at_zero = (value_o == '0);
  assign expire  = ptick_i & at_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (load_wr_i)    cnt_d = load_val_i;
    else if (ptick_i) begin
      if (!at_zero)        cnt_d = (value_o - 1'b1) & top;
      else if (oneshot_i)  cnt_d = value_o;
      else if (periodic_i) cnt_d = limit_i;
      else                 cnt_d = top;
    end
  end

  always_comb begin
    raw_d = raw_q;
    if (expire)         raw_d = 1'b1;
    else if (iclr_wr_i) raw_d = 1'b0;
    halt_d = halt_q;
    if (load_wr_i | ctrl_wr_i)   halt_d = 1'b0;
    else if (expire & oneshot_i) halt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      raw_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      raw_q  <= raw_d;
      halt_q <= halt_d;
    end
  end

  assign raw_o    = raw_q;
  assign halted_o = halt_q;

  // R11
  raw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_o && !iclr_wr_i) |=> raw_o);

  // R5
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptick_i && !load_wr_i && !ctrl_wr_i && value_o != '0) |=> (value_o == $past(value_o) - 1'b1));

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_o && !load_wr_i && !ctrl_wr_i) |=> $stable(value_o));
endmodule

// File: rtl/tmr_down_timer.sv
module tmr_down_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NARROW_W    = 16,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CTRL_W = $bits(tmr_ctrl_t);

  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rs_q[SYNC_STAGES-1];

  tmr_ctrl_t         ctrl_q, ctrl_d;
  logic [DATA_W-1:0] limit_q, limit_d, value;
  logic              wr_load, wr_bg, wr_ctrl, wr_iclr, pre_clr, ptick, raw, halted;

  assign wr_load = bus_we & (bus_addr == RA_LOAD);
  assign wr_bg   = bus_we & (bus_addr == RA_BGLOAD);
  assign wr_ctrl = bus_we & (bus_addr == RA_CTRL);
  assign wr_iclr = bus_we & (bus_addr == RA_ICLR);
  assign pre_clr = wr_ctrl & (bus_wdata[3:2] != ctrl_q.div_sel);

  always_comb begin
    ctrl_d  = ctrl_q;
    limit_d = limit_q;
    if (wr_ctrl)          ctrl_d  = tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
    if (wr_load | wr_bg)  limit_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q  <= tmr_ctrl_t'(CTRL_RST);
      limit_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      limit_q <= limit_d;
    end
  end

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run_i   (ctrl_q.run & ~halted),
    .tick_i  (tick_en),
    .sel_i   (ctrl_q.div_sel),
    .clr_i   (pre_clr),
    .ptick_o (ptick)
  );

  tmr_core #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ptick_i    (ptick),
    .wide_i     (ctrl_q.wide),
    .periodic_i (ctrl_q.periodic),
    .oneshot_i  (ctrl_q.oneshot),
    .limit_i    (limit_q),
    .load_wr_i  (wr_load),
    .load_val_i (bus_wdata),
    .ctrl_wr_i  (wr_ctrl),
    .iclr_wr_i  (wr_iclr),
    .value_o    (value),
    .raw_o      (raw),
    .halted_o   (halted)
  );

  always_comb begin
    case (bus_addr)
      RA_LOAD, RA_BGLOAD: bus_rdata = limit_q;
      RA_VALUE:           bus_rdata = value;
      RA_CTRL:            bus_rdata = DATA_W'(ctrl_q);
      RA_RAW:             bus_rdata = DATA_W'(raw);
      RA_MASKED:          bus_rdata = DATA_W'(raw & ctrl_q.ie);
      default:            bus_rdata = '0;
    endcase
  end

  assign irq = raw & ctrl_q.ie;

  // R10
  value_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_we && bus_addr == RA_VALUE && !ptick) |=> $stable(value));
endmodule

// File: tb/tb_tmr_down_timer.sv
`timescale 1ns/1ps
module tb_tmr_down_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic [2:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tmr_down_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference
  bit [31:0] m_cnt, m_limit;
  bit [7:0]  m_ctrl;
  bit        m_raw, m_halt;
  int        m_pre;

  function automatic bit [31:0] m_top();
    return m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic bit [31:0] m_read(input bit [2:0] a);
    case (a)
      3'd0, 3'd6: return m_limit;
      3'd1:       return m_cnt & m_top();
      3'd2:       return {24'd0, m_ctrl};
      3'd4:       return {31'd0, m_raw};
      3'd5:       return {31'd0, m_raw & m_ctrl[5]};
      default:    return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_limit = 0; m_ctrl = 8'h20; m_raw = 0; m_halt = 0; m_pre = 0;
    end else begin
      bit run, pt, ex;
      int mask;
      bit [31:0] eff, n_cnt;
      run  = m_ctrl[7] && !m_halt;
      mask = (m_ctrl[3:2] == 2'b01) ? 15 : (m_ctrl[3:2] == 2'b10) ? 255 : 0;
      pt   = run && tick_en && ((m_pre & mask) == mask);
      eff  = m_cnt & m_top();
      ex   = pt && (eff == 0);
      n_cnt = m_cnt;
      if (bus_we && bus_addr == 3'd0) n_cnt = bus_wdata;
      else if (pt) begin
        if (eff != 0)       n_cnt = (eff - 1) & m_top();
        else if (m_ctrl[0]) n_cnt = 0;
        else if (m_ctrl[6]) n_cnt = m_limit;
        else                n_cnt = m_top();
      end
      if (bus_we && bus_addr == 3'd2 && bus_wdata[3:2] != m_ctrl[3:2]) m_pre = 0;
      else if (run && tick_en) m_pre = (m_pre + 1) % 256;
      if (bus_we && (bus_addr == 3'd0 || bus_addr == 3'd2)) m_halt = 0;
      else if (ex && m_ctrl[0]) m_halt = 1;
      if (ex) m_raw = 1;
      else if (bus_we && bus_addr == 3'd3) m_raw = 0;
      m_cnt = n_cnt;
      if (bus_we && (bus_addr == 3'd0 || bus_addr == 3'd6)) m_limit = bus_wdata;
      if (bus_we && bus_addr == 3'd2) m_ctrl = bus_wdata[7:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison, 3 ns after the edge
  always @(posedge clk) begin
    #3;
    if (rst_n && cmp_on && !done) begin
      chk("R2 cycle read", bus_rdata, m_read(bus_addr));
      chk("R12 cycle irq", {31'd0, irq}, {31'd0, m_raw & m_ctrl[5]});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 3'd1; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
    bus_addr = 3'd1;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic expect_rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(150000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; bus_we = 1'b0; bus_addr = 3'd1; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cmp_on = 1'b1;

    // R1 / R2 reset state and map
    expect_rd("R1 limit", 3'd0, 32'h0);
    expect_rd("R1 value", 3'd1, 32'h0);
    expect_rd("R1 ctrl", 3'd2, 32'h20);
    expect_rd("R2 clr reads 0", 3'd3, 32'h0);
    expect_rd("R1 raw", 3'd4, 32'h0);
    expect_rd("R1 masked", 3'd5, 32'h0);
    expect_rd("R2 bg limit", 3'd6, 32'h0);
    expect_rd("R2 addr7", 3'd7, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R7 periodic reload, R11 / R12 flag and irq
    wr(3'd0, 32'd5);
    wr(3'd2, 32'hE2);
    ticks(6);
    expect_rd("R7 reload", 3'd1, 32'd5);
    expect_rd("R11 raw set", 3'd4, 32'd1);
    chk("R12 irq high", {31'd0, irq}, 32'd1);
    expect_rd("R12 masked", 3'd5, 32'd1);
    wr(3'd2, 32'hC2);
    chk("R12 irq masked", {31'd0, irq}, 32'd0);
    expect_rd("R12 masked 0", 3'd5, 32'd0);
    expect_rd("R12 raw kept", 3'd4, 32'd1);
    expect_rd("R3 ctrl readback", 3'd2, 32'hC2);
    wr(3'd3, 32'hDEAD);
    expect_rd("R11 cleared", 3'd4, 32'd0);

    // R6 free-running 16-bit wrap
    wr(3'd0, 32'd2);
    wr(3'd2, 32'hA0);
    ticks(3);
    expect_rd("R6 wrap 16b", 3'd1, 32'h0000_FFFF);
    expect_rd("R11 set on wrap", 3'd4, 32'd1);
    wr(3'd3, 32'd0);

    // R5 16-bit masking
    wr(3'd0, 32'h1234_0002);
    wr(3'd2, 32'hC0);
    expect_rd("R5 narrow read", 3'd1, 32'h2);
    ticks(3);
    expect_rd("R5 narrow reload", 3'd1, 32'h2);
    wr(3'd3, 32'd0);

    // R4 prescaler
    wr(3'd0, 32'd100);
    wr(3'd2, 32'hC6);
    ticks(32);
    expect_rd("R4 div16", 3'd1, 32'd98);
    wr(3'd2, 32'hCA);
    ticks(255);
    expect_rd("R4 div256 early", 3'd1, 32'd98);
    ticks(1);
    expect_rd("R4 div256", 3'd1, 32'd97);
    wr(3'd2, 32'hCE);
    ticks(3);
    expect_rd("R4 sel11", 3'd1, 32'd94);
    wr(3'd2, 32'h4E);
    ticks(5);
    expect_rd("R4 run off", 3'd1, 32'd94);

    // R10 value write ignored
    wr(3'd1, 32'h1234);
    expect_rd("R10 value kept", 3'd1, 32'd94);

    // R9 background load
    wr(3'd2, 32'hC2);
    wr(3'd6, 32'h10);
    expect_rd("R9 bg no reload", 3'd1, 32'd94);
    expect_rd("R9 limit at 0", 3'd0, 32'h10);
    expect_rd("R9 limit at 6", 3'd6, 32'h10);
    ticks(95);
    expect_rd("R9 bg used at wrap", 3'd1, 32'h10);

    // R13 load beats tick
    @(negedge clk);
    tick_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 32'd50;
    @(negedge clk);
    tick_en = 1'b0; bus_we = 1'b0; bus_addr = 3'd1; bus_wdata = '0;
    expect_rd("R13 load wins", 3'd1, 32'd50);

    // R3 upper bits dropped
    wr(3'd2, 32'hFFFF_FFFF);
    expect_rd("R3 ctrl 8 bits", 3'd2, 32'hFF);
    wr(3'd2, 32'h40);

    // R8 one-shot
    wr(3'd3, 32'd0);
    wr(3'd0, 32'd2);
    wr(3'd2, 32'hA3);
    ticks(10);
    expect_rd("R8 halted", 3'd1, 32'd0);
    expect_rd("R8 raw", 3'd4, 32'd1);
    wr(3'd3, 32'd0);
    ticks(5);
    expect_rd("R8 fires once", 3'd4, 32'd0);
    wr(3'd0, 32'd1);
    ticks(2);
    expect_rd("R8 restart by load", 3'd4, 32'd1);
    expect_rd("R8 at zero", 3'd1, 32'd0);
    wr(3'd3, 32'd0);
    wr(3'd2, 32'hA3);
    ticks(1);
    expect_rd("R8 restart by ctrl", 3'd4, 32'd1);

    // random traffic, compared every cycle (R11 set/clear collisions)
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      tick_en = ($urandom % 4) != 0;
      if ($urandom % 8 == 0) begin
        bus_we   = 1'b1;
        bus_addr = 3'($urandom % 8);
        case (bus_addr)
          3'd0, 3'd6: bus_wdata = $urandom % 40;
          3'd2:       bus_wdata = ($urandom % 256) | 32'h80;
          default:    bus_wdata = $urandom;
        endcase
      end else begin
        bus_we   = 1'b0;
        bus_addr = 3'($urandom % 8);
      end
    end
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 3'd1; tick_en = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule